// File: doc/BRIEF.md
# Bit-Test Forward Branch Unit

This block carries out the execute step of a conditional skip instruction. It looks at one bit of a wide register-pair value and compares it with a required polarity. If they match, it adds a short forward displacement either to the program counter or to a general data register C. The bit is picked by a 3-bit code from a fixed, sparse set of positions. These are the five lowest bits plus the top bit of each quarter, half and whole of the pair.

The surrounding core supplies the current PC and C values, the operand pair and the decoded instruction fields. It then asserts an execute strobe for one cycle. On that clock edge the block registers three things: the taken flag, the next PC and the next C. The core writes these back. Register-file access and instruction fetch stay outside the block.

Top module: `bit_test_branch`

## Requirements
- R1: A synchronous reset clears the taken flag, the next-PC output and the next-C output to zero on the following clock edge.
- R2: The 3-bit code selects the tested bit of the pair as follows: codes 0 to 4 test bits 0 to 4, code 5 tests bit 7, code 6 tests bit 15 and code 7 tests bit 31. Bit 0 is the least significant bit.
- R3: With the polarity input at 1 the condition holds when the selected bit is 1. With it at 0 the condition holds when the selected bit is 0. The registered taken flag equals the condition.
- R4: When the condition holds and the target select is 0 (PC), the next PC is current PC + 1 + displacement modulo 4096, and the next C equals the current C.
- R5: When the condition holds and the target select is 1 (register C), the next C is current C + displacement modulo 65536, and the next PC is current PC + 1 modulo 4096.
- R6: When the condition fails, the taken flag is 0, the next PC is current PC + 1 modulo 4096, and the next C equals the current C.
- R7: In a cycle where the execute strobe is low, all three outputs keep their values whatever the other inputs do.
- R8: Bits of the pair other than the selected one have no effect on the outcome.
- R9: All outputs change exactly one clock edge after the execute strobe is sampled high, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; registers a new outcome |
| pair_val | input | 32 | Register-pair operand holding the tested bit |
| bit_code | input | 3 | Tested-bit selection code |
| want_one | input | 1 | Polarity: 1 branches on a set bit, 0 on a clear bit |
| disp | input | 5 | Forward displacement, 0 to 31 |
| to_creg | input | 1 | Target select: 0 = PC, 1 = register C |
| pc_cur | input | 12 | Current program counter |
| c_cur | input | 16 | Current value of register C |
| taken_o | output | 1 | Registered condition outcome |
| pc_new | output | 12 | Registered next program counter |
| c_new | output | 16 | Registered next value of register C |

## Verification
The bench builds the block with its default widths: a 32-bit pair, a 12-bit PC and a 16-bit C register. At these widths the three upper test positions land on bits 7, 15 and 31. A PC of 4095 with a displacement of 31 shows the modulo-4096 wrap, and a C of 0xFFF0 shows the 16-bit wrap. Each selection code is run with only its own bit set and again with only its own bit clear, under both polarities. This exposes any wrong mapping as well as any leakage from neighbouring bits.

// File: rtl/tbb_pkg.sv
package tbb_pkg;

    localparam int unsigned CODE_W  = 3;
    localparam int unsigned N_CODES = 1 << CODE_W;

    typedef enum logic {
        TGT_PC   = 1'b0,
        TGT_CREG = 1'b1
    } tbb_target_e;

    // Sparse tested-bit map: five low bits, then the top bit of the
    // lower quarter, lower half and whole pair.
    function automatic int unsigned tbb_bit_pos(input int unsigned code,
                                                input int unsigned pair_w);
        int unsigned pos;
        if (code < 5)       pos = code;
        else if (code == 5) pos = pair_w / 4 - 1;
        else if (code == 6) pos = pair_w / 2 - 1;
        else                pos = pair_w - 1;
        return pos;
    endfunction

endpackage

// File: rtl/tbb_bit_select.sv
module tbb_bit_select
    import tbb_pkg::*;
#(
    parameter int unsigned PAIR_W = 32
) (
    input  logic [PAIR_W-1:0] pair,
    input  logic [CODE_W-1:0] code,
    output logic              sel_bit
);

    logic [N_CODES-1:0] cand;

    for (genvar k = 0; k < N_CODES; k++) begin : g_cand
        localparam int unsigned POS = tbb_bit_pos(k, PAIR_W);
        assign cand[k] = pair[POS];
    end

    assign sel_bit = cand[code];

endmodule

// File: rtl/tbb_wrap_add.sv
module tbb_wrap_add #(
    parameter int unsigned W  = 12,
    parameter int unsigned DW = 5
) (
    input  logic [W-1:0]  base,
    input  logic [DW-1:0] inc,
    input  logic          cin,
    output logic [W-1:0]  sum
);

    localparam int unsigned PAD = W - DW;

    assign sum = base + {{PAD{1'b0}}, inc} + {{(W-1){1'b0}}, cin};

endmodule

// File: rtl/bit_test_branch.sv
module bit_test_branch
    import tbb_pkg::*;
#(
    parameter int unsigned PAIR_W = 32,
    parameter int unsigned PC_W   = 12,
    parameter int unsigned C_W    = 16,
    parameter int unsigned DISP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [PAIR_W-1:0] pair_val,
    input  logic [CODE_W-1:0] bit_code,
    input  logic              want_one,
    input  logic [DISP_W-1:0] disp,
    input  logic              to_creg,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [C_W-1:0]    c_cur,
    output logic              taken_o,
    output logic [PC_W-1:0]   pc_new,
    output logic [C_W-1:0]    c_new
);

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] pc;
        logic [C_W-1:0]  c;
    } outcome_t;

    outcome_t    state_d, state_q;
    logic        tested_bit;
    logic        cond_hit;
    tbb_target_e target;
    logic [DISP_W-1:0] pc_inc;
    logic [DISP_W-1:0] c_inc;
    logic [PC_W-1:0]   pc_sum;
    logic [C_W-1:0]    c_sum;

    tbb_bit_select #(.PAIR_W(PAIR_W)) u_sel (
        .pair    (pair_val),
        .code    (bit_code),
        .sel_bit (tested_bit)
    );

    assign target   = tbb_target_e'(to_creg);
    assign cond_hit = (tested_bit == want_one);
    assign pc_inc   = (cond_hit && target == TGT_PC)   ? disp : '0;
    assign c_inc    = (cond_hit && target == TGT_CREG) ? disp : '0;

    tbb_wrap_add #(.W(PC_W), .DW(DISP_W)) u_pc_add (
        .base (pc_cur),
        .inc  (pc_inc),
        .cin  (1'b1),
        .sum  (pc_sum)
    );

    tbb_wrap_add #(.W(C_W), .DW(DISP_W)) u_c_add (
        .base (c_cur),
        .inc  (c_inc),
        .cin  (1'b0),
        .sum  (c_sum)
    );

    always_comb begin
        state_d = state_q;
        if (exec_en) begin
            state_d.taken = cond_hit;
            state_d.pc    = pc_sum;
            state_d.c     = c_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign taken_o = state_q.taken;
    assign pc_new  = state_q.pc;
    assign c_new   = state_q.c;

endmodule

// File: rtl/tbb_checker.sv
module tbb_checker #(
    parameter int unsigned PC_W = 12,
    parameter int unsigned C_W  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            exec_en,
    input logic            to_creg,
    input logic [PC_W-1:0] pc_cur,
    input logic [C_W-1:0]  c_cur,
    input logic            taken_o,
    input logic [PC_W-1:0] pc_new,
    input logic [C_W-1:0]  c_new
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!taken_o && pc_new == '0 && c_new == '0));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> ($stable(taken_o) && $stable(pc_new) && $stable(c_new)));

    assert_creg_target_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_en && to_creg) |=> (pc_new == $past(pc_cur) + PC_ONE));

    assert_pc_target_keeps_c_R4: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !to_creg) |=> (c_new == $past(c_cur)));

    assert_not_taken_step_R6: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> (taken_o || (pc_new == $past(pc_cur) + PC_ONE && c_new == $past(c_cur))));

endmodule

bind bit_test_branch tbb_checker #(.PC_W(PC_W), .C_W(C_W)) u_tbb_chk (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .to_creg (to_creg),
    .pc_cur  (pc_cur),
    .c_cur   (c_cur),
    .taken_o (taken_o),
    .pc_new  (pc_new),
    .c_new   (c_new)
);

// File: tb/tb_bit_test_branch.sv
`timescale 1ns/1ps
module tb_bit_test_branch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [31:0] pair_val = '0;
    logic [2:0]  bit_code = '0;
    logic        want_one = 1'b0;
    logic [4:0]  disp = '0;
    logic        to_creg = 1'b0;
    logic [11:0] pc_cur = '0;
    logic [15:0] c_cur = '0;
    logic        taken_o;
    logic [11:0] pc_new;
    logic [15:0] c_new;

    always #2 clk = ~clk;

    bit_test_branch dut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .pair_val(pair_val),
        .bit_code(bit_code), .want_one(want_one), .disp(disp),
        .to_creg(to_creg), .pc_cur(pc_cur), .c_cur(c_cur),
        .taken_o(taken_o), .pc_new(pc_new), .c_new(c_new)
    );

    typedef struct {
        logic        tk;
        logic [11:0] pc;
        logic [15:0] c;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    function automatic int unsigned ref_pos(input logic [2:0] code);
        case (code)
            3'd5:    return 7;
            3'd6:    return 15;
            3'd7:    return 31;
            default: return int'(code);
        endcase
    endfunction

    task automatic check(input exp_t e);
        n_chk++;
        if (taken_o !== e.tk || pc_new !== e.pc || c_new !== e.c) begin
            n_bad++;
            $display("FAIL %s: got tk=%0b pc=%0h c=%0h, expected tk=%0b pc=%0h c=%0h",
                     e.tag, taken_o, pc_new, c_new, e.tk, e.pc, e.c);
        end
    endtask

    // Driver: one executed instruction, expected outcome pushed to scoreboard.
    task automatic drive(input logic [31:0] pv, input logic [2:0] code,
                         input logic pol, input logic [4:0] d, input logic tgt,
                         input logic [11:0] pc, input logic [15:0] c,
                         input string tag);
        logic hit;
        @(negedge clk);
        pair_val = pv; bit_code = code; want_one = pol; disp = d;
        to_creg = tgt; pc_cur = pc; c_cur = c; exec_en = 1'b1;
        hit = (pv[ref_pos(code)] == pol);
        last.tk  = hit;
        last.pc  = (hit && !tgt) ? pc + 12'd1 + {7'd0, d} : pc + 12'd1;
        last.c   = (hit && tgt)  ? c + {11'd0, d} : c;
        last.tag = tag;
        q.push_back(last);
    endtask

    // Strobe low while the other inputs churn: outputs must hold.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exec_en = 1'b0;
            pair_val = ~pair_val; want_one = ~want_one; to_creg = ~to_creg;
            pc_cur = pc_cur + 12'd77; c_cur = c_cur ^ 16'h5a5a; disp = disp + 5'd3;
            last.tag = "R7 hold";
            q.push_back(last);
        end
    endtask

    // Monitor: compares one cycle after each driven cycle (R9 timing).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) check(q.pop_front());
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z.tk = 1'b0; z.pc = '0; z.c = '0; z.tag = "R1 reset";
        repeat (3) @(negedge clk);
        check(z);
        rst = 1'b0;
        last = z;

        // R2/R3/R8: each code with only its bit set, and only its bit clear.
        for (int k = 0; k < 8; k++) begin
            logic [31:0] one_hot;
            one_hot = 32'd1 << ref_pos(3'(k));
            drive(one_hot,  3'(k), 1'b1, 5'd4, 1'b0, 12'h100, 16'h1234, "R2 set bit pol1 taken");
            drive(~one_hot, 3'(k), 1'b1, 5'd4, 1'b0, 12'h100, 16'h1234, "R8 other bits set, R6 not taken");
            drive(~one_hot, 3'(k), 1'b0, 5'd9, 1'b0, 12'h200, 16'h0042, "R3 clear bit pol0 taken");
            drive(one_hot,  3'(k), 1'b0, 5'd9, 1'b1, 12'h300, 16'h0042, "R3 set bit pol0 not taken");
        end

        // R4: PC target, wrap and zero displacement.
        drive(32'h8000_0000, 3'd7, 1'b1, 5'd31, 1'b0, 12'hfff, 16'hbeef, "R4 pc wrap");
        drive(32'h0000_0080, 3'd5, 1'b1, 5'd0,  1'b0, 12'h0a0, 16'h0001, "R4 zero disp");
        // R5: C target, wrap; PC steps by one.
        drive(32'h0000_8000, 3'd6, 1'b1, 5'd31, 1'b1, 12'hfff, 16'hfff0, "R5 c wrap");
        drive(32'h0000_0000, 3'd0, 1'b0, 5'd17, 1'b1, 12'h010, 16'h0100, "R5 c add");
        // R6: not taken with C target leaves C alone.
        drive(32'hffff_ffff, 3'd3, 1'b0, 5'd17, 1'b1, 12'h7ff, 16'h0100, "R6 not taken c target");
        // R7: strobe low holds.
        idle(4);
        drive(32'h0000_0010, 3'd4, 1'b1, 5'd5, 1'b0, 12'h020, 16'h0003, "R9 back to back a");
        drive(32'h0000_0010, 3'd4, 1'b1, 5'd6, 1'b1, 12'h030, 16'h0003, "R9 back to back b");
        idle(2);

        // R1: reset mid-run clears outputs.
        @(negedge clk);
        exec_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(z);
        rst = 1'b0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule